// File: doc/BRIEF.md
# Constant-Time Binary Modular Inverter

This block returns the inverse of an operand `a` modulo an odd modulus `p`, for `0 < a < p` and `gcd(a, p) = 1`. The modulus is normally prime. The method is binary extended Euclid. Four working registers are used: two remainders and two coefficients.

Each iteration computes every candidate update. A decision made from the parities and from a one-hot magnitude comparison then picks one of them. The number of iterations is fixed at twice the operand width, whatever the values are. So the time from acceptance to result is the same for every input, and the same arithmetic is evaluated on every cycle.

The block is used as a single-transaction unit:

- An operand pair enters over a valid/ready handshake. While a computation is in flight, ready is low, and anything offered then is left untouched.
- The result leaves as a one-cycle valid pulse, with no ready. Because the latency is fixed, the consumer must be able to take the result in that cycle. The data stays on the output until the next result replaces it.

Top module: `inv_core`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A transfer happens on a rising edge where both `in_valid` and `in_ready` are 1. `in_a` and `in_p` are captured on that edge. `in_valid` offered while `in_ready` is 0 is ignored: it changes neither the result nor the timing.
- R3: If a transfer happens on edge E, `out_valid` is 1 for exactly one cycle, the one following edge E+2N+2, for every operand value.
- R4: For an odd `p` of at least 3 and `0 < a < p` with `gcd(a,p)=1`, `out_inv` is the value x in [0, p) with a·x ≡ 1 (mod p).
- R5: Every delivered result is strictly below the modulus captured with it.
- R6: Boundary operands: a=1 gives 1, and a=p−1 gives p−1.
- R7: With a=0 the output value is unspecified. `out_valid` still rises on the schedule of R3.
- R8: Between pulses, `out_inv` keeps the last delivered result.
- R9: `in_ready` is 0 from the cycle after a transfer until the `out_valid` cycle, and is 1 in the `out_valid` cycle. A new transfer can therefore take place on the edge that ends the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to accept |
| in_a | input | N | Operand to invert |
| in_p | input | N | Odd modulus |
| out_valid | output | 1 | One-cycle result strobe |
| out_inv | output | N | Inverse of the accepted operand |

## Verification
When a transfer is seen on edge E, the result pulse and its data are due in the cycle after edge E+2N+2. Ready is due back in that same cycle, and no earlier. The bench keeps its own model of the transaction:

- It counts edges from the observed acceptance and computes the expected inverse by integer extended Euclid.
- On the falling edge of every cycle it compares `out_valid`, `in_ready` and, when a pulse is due, `out_inv` against that model.
- Between pulses it checks that the output holds the previous result.

// File: rtl/inv_pkg.sv
package inv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_PICK,
    ST_EMIT
  } inv_state_e;

  typedef enum logic [2:0] {
    STEP_HOLD,
    STEP_HALF_U,
    STEP_HALF_V,
    STEP_SUB_UV,
    STEP_SUB_VU
  } inv_step_e;

  // one-hot magnitude relation between the two remainders
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } inv_rel_t;

endpackage

// File: rtl/inv_modsub.sv
// (x - y) mod m for x, y in [0, m)
module inv_modsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] m,
  output logic [W-1:0] d
);
  logic [W:0]   raw;
  logic [W-1:0] wrapped;

  assign raw     = {1'b0, x} - {1'b0, y};
  assign wrapped = raw[W-1:0] + m;
  assign d       = raw[W] ? wrapped : raw[W-1:0];
endmodule

// File: rtl/inv_halve.sv
// x / 2 mod m for odd m; mh = m >> 1
module inv_halve #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] mh,
  output logic [W-1:0] h
);
  logic [W-1:0] shr;

  assign shr = x >> 1;
  assign h   = x[0] ? (shr + mh + W'(1)) : shr;
endmodule

// File: rtl/inv_cmp.sv
module inv_cmp
  import inv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output inv_rel_t     rel
);
  always_comb begin
    rel.gt = (a > b);
    rel.lt = (a < b);
    rel.eq = (a == b);
  end
endmodule

// File: rtl/inv_ctrl.sv
module inv_ctrl
  import inv_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic in_ready,
  output logic load_en,
  output logic step_en,
  output logic pick_en,
  output logic emit_en,
  output logic out_valid
);
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);
  localparam int LW = $clog2(ITERS + 4);
  localparam logic [LW-1:0] DUE = LW'(ITERS + 2);

  inv_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          vld_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign load_en   = start && in_ready;
  assign step_en   = (state_q == ST_RUN);
  assign pick_en   = (state_q == ST_PICK);
  assign emit_en   = (state_q == ST_EMIT);
  assign out_valid = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= (state_q == ST_EMIT);
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_PICK;
        end
        ST_PICK: state_q <= ST_EMIT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // edges since acceptance, for the latency check
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lat_q <= '1;
    else if (load_en)        lat_q <= '0;
    else if (lat_q != '1)    lat_q <= lat_q + 1'b1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat_q == DUE));

  // R3
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in_ready) |=> !in_ready);

  // R9
  ready_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

// File: rtl/inv_core.sv
module inv_core
  import inv_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_p,
  output logic         out_valid,
  output logic [N-1:0] out_inv
);
  localparam int ITERS = 2 * N;
  localparam logic [N-1:0] ONE = N'(1);

  logic load_en, step_en, pick_en, emit_en;

  inv_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (in_valid),
    .in_ready (in_ready),
    .load_en  (load_en),
    .step_en  (step_en),
    .pick_en  (pick_en),
    .emit_en  (emit_en),
    .out_valid(out_valid)
  );

  logic [N-1:0] u_q, v_q, x1_q, x2_q, p_q, ph_q, res_q;
  logic         u_unit_q;

  // lane 0 owns (u, x1); lane 1 owns (v, x2)
  logic [N-1:0] val   [2];
  logic [N-1:0] xv    [2];
  logic [N-1:0] gap   [2];
  logic [N-1:0] xdiff [2];
  logic [N-1:0] xhalf [2];
  logic [N-1:0] xdhalf[2];

  assign val[0] = u_q;
  assign val[1] = v_q;
  assign xv[0]  = x1_q;
  assign xv[1]  = x2_q;

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    localparam int OT = 1 - ln;

    assign gap[ln] = val[ln] - val[OT];

    inv_modsub #(.W(N)) u_xsub (
      .x(xv[ln]), .y(xv[OT]), .m(p_q), .d(xdiff[ln])
    );
    inv_halve #(.W(N)) u_xhalf (
      .x(xv[ln]), .mh(ph_q), .h(xhalf[ln])
    );
    inv_halve #(.W(N)) u_dhalf (
      .x(xdiff[ln]), .mh(ph_q), .h(xdhalf[ln])
    );
  end

  inv_rel_t rel;
  inv_cmp #(.W(N)) u_cmp (.a(u_q), .b(v_q), .rel(rel));

  inv_step_e step;
  always_comb begin
    if (u_q == ONE || v_q == ONE) step = STEP_HOLD;
    else if (!u_q[0])             step = STEP_HALF_U;
    else if (!v_q[0])             step = STEP_HALF_V;
    else if (rel.gt)              step = STEP_SUB_UV;
    else if (rel.lt)              step = STEP_SUB_VU;
    else                          step = STEP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q      <= '0;
      v_q      <= '0;
      x1_q     <= '0;
      x2_q     <= '0;
      p_q      <= '0;
      ph_q     <= '0;
      res_q    <= '0;
      u_unit_q <= 1'b0;
    end else begin
      if (load_en) begin
        u_q  <= in_a;
        v_q  <= in_p;
        x1_q <= ONE;
        x2_q <= '0;
        p_q  <= in_p;
        ph_q <= in_p >> 1;
      end else if (step_en) begin
        case (step)
          STEP_HALF_U: begin u_q <= u_q >> 1;    x1_q <= xhalf[0];  end
          STEP_HALF_V: begin v_q <= v_q >> 1;    x2_q <= xhalf[1];  end
          STEP_SUB_UV: begin u_q <= gap[0] >> 1; x1_q <= xdhalf[0]; end
          STEP_SUB_VU: begin v_q <= gap[1] >> 1; x2_q <= xdhalf[1]; end
          default: ;
        endcase
      end
      if (pick_en) u_unit_q <= (u_q == ONE);
      if (emit_en) res_q <= u_unit_q ? x1_q : x2_q;
    end
  end

  assign out_inv = res_q;

  // R5
  x_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (x1_q < p_q && x2_q < p_q));

  // R4
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_en |-> (u_q == ONE || v_q == ONE || u_q == '0));

  // R4
  rel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rel.gt, rel.lt, rel.eq}) == 1);

  // R5
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_inv < p_q));
endmodule

// File: tb/test_inv_core.sv
`timescale 1ns/1ps
module test_inv_core;
  localparam int N = 16;
  localparam int K = 2 * N;
  localparam int WD_CYCLES = 50000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [N-1:0] in_a = '0;
  logic [N-1:0] in_p = '0;
  logic         in_ready, out_valid;
  logic [N-1:0] out_inv;

  always #2.5 clk = ~clk;

  inv_core #(.N(N)) i_inv_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_p(in_p), .out_valid(out_valid), .out_inv(out_inv)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint ref_inv(longint a, longint m);
    longint t = 0, nt = 1, r = m, nr = a, q, tmp;
    while (nr != 0) begin
      q = r / nr;
      tmp = t - q * nt; t = nt; nt = tmp;
      tmp = r - q * nr; r = nr; nr = tmp;
    end
    if (t < 0) t += m;
    return t;
  endfunction

  // behavioural transaction model
  longint cyc = 0;
  bit     pend = 0;
  longint due = 0;
  longint exp_val = 0, exp_a = 0, exp_p = 0;
  bit     have_last = 0;
  longint last_val = 0;

  always @(posedge clk) if (rst_n) cyc++;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_ov, exp_rdy;
      exp_ov  = pend && (cyc == due);
      exp_rdy = !(pend && (cyc < due));
      chk(out_valid == exp_ov, "R3 out_valid timing", out_valid, exp_ov);
      chk(in_ready == exp_rdy, "R9 in_ready", in_ready, exp_rdy);
      if (exp_ov) begin
        if (exp_a != 0) begin
          chk(out_inv == exp_val, "R4 inverse value", out_inv, exp_val);
          chk(out_inv < exp_p, "R5 result range", out_inv, exp_p);
          if (exp_a == 1 || exp_a == exp_p - 1)
            chk(out_inv == exp_val, "R6 boundary operand", out_inv, exp_val);
        end else begin
          chk(out_valid == 1'b1, "R7 zero operand keeps schedule", out_valid, 1);
        end
        last_val  = out_inv;
        have_last = 1;
        pend      = 0;
      end else if (have_last) begin
        chk(out_inv == last_val, "R8 result held", out_inv, last_val);
      end
      if (in_valid && exp_rdy) begin
        pend    = 1;
        due     = cyc + K + 3;
        exp_a   = in_a;
        exp_p   = in_p;
        exp_val = (in_a != 0) ? ref_inv(in_a, in_p) : 0;
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic send(int a, int p);
    @(posedge clk); #1;
    in_a = a[N-1:0];
    in_p = p[N-1:0];
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (K + 6) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    send(1, 65521); settle();            // R6
    send(65520, 65521);                  // R6, back-to-back follows
    send(12345, 65521);
    send(2, 65521);
    settle();
    for (int a = 1; a < 7; a++) send(a, 7);
    settle();
    send(1, 3); send(2, 3); settle();
    send(2, 65535); send(65534, 65535); settle();

    // R2: offers while busy must be ignored
    send(40000, 65521);
    in_a = 7; in_p = 11; in_valid = 1'b1;
    repeat (10) @(posedge clk);
    #1 in_valid = 1'b0;
    settle();

    // R7
    send(0, 65521); settle();
    send(9999, 10007); settle();

    chk(pend == 0, "R3 all results delivered", pend, 0);
    summary();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
      summary();
    end
  end
endmodule